// File: doc/BRIEF.md
# Paired instruction cycle accumulator

This block charges the cost of each retired instruction to three running time counters: a main cycle counter, a global clock counter and a signed pending-interrupt countdown. Bus accesses sit on a four-cycle grid, so a cost is normally rounded up to the next multiple of four. Two back-to-back instructions can share a grid slot when the first ends two cycles off the grid and the second either also ends two cycles off it or carries an indexed-addressing misalignment penalty. When they share a slot, the rounding is skipped and the pair costs four cycles less.

Each instruction arrives as one beat on a valid/ready input. The beat carries a raw cycle count, an opcode family index, a misalignment penalty and an entry-point select. The entry-point select picks either the pairing-aware path or a plain path that only rounds. A programmable family-by-family table decides which opcode families may pair. A frequency-shift input divides every charge by a power of two before it reaches the counters.

The only back-pressure comes from table writes. `in_ready` is low in any cycle where `tbl_we` is high. A beat is accepted on a rising clock edge where both `in_valid` and `in_ready` are high, and it costs exactly one cycle.

Top module: `pair_cycle_accumulator`

## Requirements
- R1: After reset, the three counters are zero, `pair_pulse` is low and `irq_expired` is high. The remembered previous cost and family are cleared, so the first instruction after reset never pairs, whatever the table holds.
- R2: An unpaired instruction on the pairing path is charged (raw + penalty), rounded up to the next multiple of 4.
- R3: A pairing-path instruction pairs only when all three of these hold: the table bit at (previous family, current family) is 1; the remembered previous cost mod 4 is 2; and either the current raw count mod 4 is 2 or the penalty is nonzero.
- R4: A paired instruction whose raw count mod 4 is 2 is charged raw − 2. No penalty is added and no rounding is applied.
- R5: A paired instruction whose raw count mod 4 is not 2 (the nonzero-penalty case) is charged its raw count unchanged.
- R6: Every accepted pairing-path instruction sets the remembered previous cost to (raw + penalty) mod 4 and the remembered family to its own family.
- R7: The charge is shifted right by `freq_shift` before it is applied to the counters.
- R8: The shifted charge is added to `main_count` and to `global_count`, and is subtracted from `irq_countdown`. All three registered results appear one clock after the beat is accepted.
- R9: On the plain path (`in_mode_pair` = 0), the charge is the raw count rounded up to a multiple of 4. The penalty and the table are ignored, and the remembered previous cost and family are left unchanged.
- R10: `pair_pulse` is high for exactly the one cycle after an accepted beat that paired, and low otherwise.
- R11: `irq_expired` is high whenever `irq_countdown`, read as a two's-complement number, is zero or negative.
- R12: A table write on a rising edge with `tbl_we` = 1 stores `tbl_bit` at (`tbl_prev`, `tbl_cur`). While `tbl_we` is high, `in_ready` is low and no beat is accepted.
- R13: `irq_load` = 1 loads `irq_countdown` with `irq_load_val`. If a beat is accepted in the same cycle, the load takes priority over the subtraction, but the charge is still added to the other two counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction beat valid |
| in_ready | output | 1 | Beat can be accepted (low during a table write) |
| in_cycles | input | CYC_W | Raw cycle count of the instruction |
| in_family | input | FAM_W | Opcode family index |
| in_penalty | input | PEN_W | Indexed-addressing misalignment penalty |
| in_mode_pair | input | 1 | 1 = pairing path, 0 = plain rounding path |
| freq_shift | input | SHF_W | Right shift applied to every charge |
| tbl_we | input | 1 | Pairing table write enable |
| tbl_prev | input | FAM_W | Table row: previous family |
| tbl_cur | input | FAM_W | Table column: current family |
| tbl_bit | input | 1 | Value written into the table |
| irq_load | input | 1 | Load the interrupt countdown |
| irq_load_val | input | CNT_W | Countdown load value |
| main_count | output | CNT_W | Main cycle counter |
| global_count | output | CNT_W | Global clock counter |
| irq_countdown | output | CNT_W | Pending-interrupt countdown (two's complement) |
| irq_expired | output | 1 | Countdown is zero or below |
| pair_pulse | output | 1 | One-cycle flag after a paired instruction |

## Verification
The bench goes after several corner cases, each of which a faulty design would get wrong in a visible way.
- The first instruction after reset has an enabled table entry. A design that fails to clear the history would wrongly charge it 12 instead of 16.
- A plain-path instruction is placed between two pairable ones. A design that lets the plain path overwrite the history would lose the pairing that follows.
- A table write is held against a valid beat. A design without back-pressure would charge an instruction that the bench never intended to be accepted.
- A countdown load is made in the same cycle as a charge. A design with the wrong priority would show the subtracted value.
- A case with penalty 4 and a raw count that is a multiple of four is included. It exposes a design that trims 2 cycles in that case, or that adds the penalty back.

// File: rtl/ccu_pkg.sv
package ccu_pkg;

  localparam int CCU_FAM_W = 6;
  localparam int CCU_CYC_W = 8;
  localparam int CCU_PEN_W = 3;
  localparam int CCU_CNT_W = 32;
  localparam int CCU_SHF_W = 2;

  // How one instruction's charge is formed
  typedef enum logic [1:0] {
    KIND_PLAIN = 2'd0,  // plain entry: round raw count only
    KIND_ROUND = 2'd1,  // pairing entry, no pair: round raw + penalty
    KIND_TRIM  = 2'd2,  // paired, raw count two off the grid: raw - 2
    KIND_KEEP  = 2'd3   // paired through penalty: raw unchanged
  } charge_kind_e;

  function automatic logic half_slot(input logic [1:0] lo);
    return lo == 2'd2;
  endfunction

endpackage

// File: rtl/ccu_pair_table.sv
module ccu_pair_table #(
  parameter int FAM_W = 6
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [FAM_W-1:0] wr_prev,
  input  logic [FAM_W-1:0] wr_cur,
  input  logic             wr_bit,
  input  logic [FAM_W-1:0] rd_prev,
  input  logic [FAM_W-1:0] rd_cur,
  output logic             rd_bit
);
  localparam int ADDR_W  = 2 * FAM_W;
  localparam int ENTRIES = 1 << ADDR_W;

  logic bits_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (wr_en) bits_q[{wr_prev, wr_cur}] <= wr_bit;
  end

  assign rd_bit = bits_q[{rd_prev, rd_cur}];
endmodule

// File: rtl/ccu_charge_calc.sv
module ccu_charge_calc
  import ccu_pkg::*;
#(
  parameter int CYC_W = 8,
  parameter int PEN_W = 3,
  parameter int CHG_W = 10
) (
  input  logic [CYC_W-1:0] cycles,
  input  logic [PEN_W-1:0] penalty,
  input  logic             pair_mode,
  input  logic [1:0]       prev_mod,
  input  logic             tbl_hit,
  output logic [CHG_W-1:0] charge,
  output logic             pair_now,
  output logic [1:0]       next_mod
);
  logic [CHG_W-1:0] cyc_ext;
  logic [CHG_W-1:0] cost;
  charge_kind_e     kind;

  assign cyc_ext  = CHG_W'(cycles);
  assign cost     = cyc_ext + CHG_W'(penalty);
  assign next_mod = cost[1:0];

  assign pair_now = pair_mode && tbl_hit && half_slot(prev_mod) &&
                    (half_slot(cycles[1:0]) || (penalty != '0));

  always_comb begin
    if (!pair_mode)    kind = KIND_PLAIN;
    else if (!pair_now) kind = KIND_ROUND;
    else if (half_slot(cycles[1:0])) kind = KIND_TRIM;
    else               kind = KIND_KEEP;
    case (kind)
      KIND_PLAIN: charge = (cyc_ext + CHG_W'(3)) & ~CHG_W'(3);
      KIND_ROUND: charge = (cost + CHG_W'(3)) & ~CHG_W'(3);
      KIND_TRIM:  charge = cyc_ext - CHG_W'(2);
      default:    charge = cyc_ext;
    endcase
  end
endmodule

// File: rtl/ccu_counters.sv
module ccu_counters #(
  parameter int CNT_W = 32,
  parameter int CHG_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic [CHG_W-1:0] charge_sh,
  input  logic             irq_load,
  input  logic [CNT_W-1:0] irq_load_val,
  output logic [CNT_W-1:0] main_count,
  output logic [CNT_W-1:0] global_count,
  output logic [CNT_W-1:0] irq_countdown,
  output logic             irq_expired
);
  logic [CNT_W-1:0] main_q, glob_q, cd_q;
  logic [CNT_W-1:0] step;

  assign step = acc ? CNT_W'(charge_sh) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      main_q <= '0;
      glob_q <= '0;
      cd_q   <= '0;
    end else begin
      main_q <= main_q + step;
      glob_q <= glob_q + step;
      if (irq_load) cd_q <= irq_load_val;
      else          cd_q <= cd_q - step;
    end
  end

  assign main_count    = main_q;
  assign global_count  = glob_q;
  assign irq_countdown = cd_q;
  assign irq_expired   = cd_q[CNT_W-1] || (cd_q == '0);

  // R8: both time counters advance by the same amount every cycle
  p_same_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (main_q - $past(main_q)) == (glob_q - $past(glob_q)));

  // R8: countdown drops by the charge when not loaded
  p_countdown_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !irq_load) |=> cd_q == $past(cd_q) - CNT_W'($past(charge_sh)));

  // R11: once expired, stays expired until a load
  p_expiry_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_expired && !irq_load) |=> irq_expired);
endmodule

// File: rtl/pair_cycle_accumulator.sv
module pair_cycle_accumulator
  import ccu_pkg::*;
#(
  parameter int FAM_W = CCU_FAM_W,
  parameter int CYC_W = CCU_CYC_W,
  parameter int PEN_W = CCU_PEN_W,
  parameter int CNT_W = CCU_CNT_W,
  parameter int SHF_W = CCU_SHF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [CYC_W-1:0] in_cycles,
  input  logic [FAM_W-1:0] in_family,
  input  logic [PEN_W-1:0] in_penalty,
  input  logic             in_mode_pair,
  input  logic [SHF_W-1:0] freq_shift,
  input  logic             tbl_we,
  input  logic [FAM_W-1:0] tbl_prev,
  input  logic [FAM_W-1:0] tbl_cur,
  input  logic             tbl_bit,
  input  logic             irq_load,
  input  logic [CNT_W-1:0] irq_load_val,
  output logic [CNT_W-1:0] main_count,
  output logic [CNT_W-1:0] global_count,
  output logic [CNT_W-1:0] irq_countdown,
  output logic             irq_expired,
  output logic             pair_pulse
);
  localparam int CHG_W = ((CYC_W > PEN_W) ? CYC_W : PEN_W) + 2;

  logic             acc;
  logic             tbl_hit;
  logic [CHG_W-1:0] charge, charge_sh;
  logic             pair_now;
  logic [1:0]       next_mod;
  logic [1:0]       prev_mod_q;
  logic [FAM_W-1:0] prev_fam_q;
  logic             pulse_q;

  assign in_ready = ~tbl_we;
  assign acc      = in_valid && in_ready;

  ccu_pair_table #(.FAM_W(FAM_W)) u_table (
    .clk     (clk),
    .wr_en   (tbl_we),
    .wr_prev (tbl_prev),
    .wr_cur  (tbl_cur),
    .wr_bit  (tbl_bit),
    .rd_prev (prev_fam_q),
    .rd_cur  (in_family),
    .rd_bit  (tbl_hit)
  );

  ccu_charge_calc #(.CYC_W(CYC_W), .PEN_W(PEN_W), .CHG_W(CHG_W)) u_calc (
    .cycles    (in_cycles),
    .penalty   (in_penalty),
    .pair_mode (in_mode_pair),
    .prev_mod  (prev_mod_q),
    .tbl_hit   (tbl_hit),
    .charge    (charge),
    .pair_now  (pair_now),
    .next_mod  (next_mod)
  );

  assign charge_sh = charge >> freq_shift;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_mod_q <= 2'd0;
      prev_fam_q <= '0;
      pulse_q    <= 1'b0;
    end else begin
      pulse_q <= acc && pair_now;
      if (acc && in_mode_pair) begin
        prev_mod_q <= next_mod;
        prev_fam_q <= in_family;
      end
    end
  end

  assign pair_pulse = pulse_q;

  ccu_counters #(.CNT_W(CNT_W), .CHG_W(CHG_W)) u_counters (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc           (acc),
    .charge_sh     (charge_sh),
    .irq_load      (irq_load),
    .irq_load_val  (irq_load_val),
    .main_count    (main_count),
    .global_count  (global_count),
    .irq_countdown (irq_countdown),
    .irq_expired   (irq_expired)
  );

  // R2: an unpaired pairing-path charge lands on the four-cycle grid
  p_round_grid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_mode_pair && !pair_now) |-> charge[1:0] == 2'b00);

  // R4: a trimmed pair charge is back on the grid
  p_pair_trim_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && pair_now && in_cycles[1:0] == 2'd2) |-> charge[1:0] == 2'b00);

  // R10: the pulse follows an accepted pairing-path beat
  p_pulse_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pair_pulse |-> $past(in_valid && in_ready && in_mode_pair));

  // R9: plain path leaves the pairing history alone
  p_plain_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !in_mode_pair) |=> ($stable(prev_mod_q) && $stable(prev_fam_q)));

  // R12: a table write stalls the counters
  p_stall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |=> ($stable(main_count) && $stable(global_count)));
endmodule

// File: tb/test_pair_cycle_accumulator.sv
module test_pair_cycle_accumulator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_cycles = '0;
  logic [5:0]  in_family = '0;
  logic [2:0]  in_penalty = '0;
  logic        in_mode_pair = 1'b0;
  logic [1:0]  freq_shift = '0;
  logic        tbl_we = 1'b0;
  logic [5:0]  tbl_prev = '0;
  logic [5:0]  tbl_cur = '0;
  logic        tbl_bit = 1'b0;
  logic        irq_load = 1'b0;
  logic [31:0] irq_load_val = '0;
  logic [31:0] main_count, global_count, irq_countdown;
  logic        irq_expired, pair_pulse;

  always #2.5 clk = ~clk;

  pair_cycle_accumulator i_pair_cycle_accumulator (.*);

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  bit          ref_tbl [4096];
  int          m_prev_mod = 0;
  int          m_prev_fam = 0;
  int unsigned m_main = 0;
  int          m_cd = 0;
  int          m_shift = 0;

  task automatic chk(string tag, string what, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int round4(int v);
    return ((v + 3) / 4) * 4;
  endfunction

  task automatic wr_tbl(int p, int c, bit b);
    @(negedge clk);
    tbl_we = 1'b1; tbl_prev = 6'(p); tbl_cur = 6'(c); tbl_bit = b;
    @(negedge clk);
    tbl_we = 1'b0;
    ref_tbl[p*64 + c] = b;
  endtask

  task automatic do_instr(string tag, int cyc, int fam, int pen, bit mode,
                          bit ld = 0, int ld_val = 0);
    int ch; bit pr;
    pr = 0;
    if (mode) begin
      pr = ref_tbl[m_prev_fam*64 + fam] && (m_prev_mod == 2) &&
           ((cyc % 4 == 2) || (pen != 0));
      if (pr) ch = (cyc % 4 == 2) ? cyc - 2 : cyc;
      else    ch = round4(cyc + pen);
      m_prev_mod = (cyc + pen) % 4;
      m_prev_fam = fam;
    end else begin
      ch = round4(cyc);
    end
    ch = ch >> m_shift;
    m_main += ch;
    if (ld) m_cd = ld_val; else m_cd -= ch;
    @(negedge clk);
    in_valid = 1'b1; in_cycles = 8'(cyc); in_family = 6'(fam);
    in_penalty = 3'(pen); in_mode_pair = mode; freq_shift = 2'(m_shift);
    irq_load = ld; irq_load_val = 32'(ld_val);
    @(negedge clk);
    in_valid = 1'b0; irq_load = 1'b0;
    chk(tag, "pair_pulse", pair_pulse, pr);
    chk(tag, "main_count", main_count, m_main);
    chk(tag, "global_count", global_count, m_main);
    chk(tag, "irq_countdown", longint'($signed(irq_countdown)), m_cd);
    chk(tag, "irq_expired", irq_expired, m_cd <= 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED_0042);
    foreach (ref_tbl[i]) ref_tbl[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "main_count", main_count, 0);
    chk("R1", "global_count", global_count, 0);
    chk("R1", "irq_countdown", irq_countdown, 0);
    chk("R1", "irq_expired", irq_expired, 1);
    chk("R1", "pair_pulse", pair_pulse, 0);
    chk("R12", "in_ready idle", in_ready, 1);

    // clear families 0..5 then set the directed pairs
    for (int p = 0; p < 6; p++)
      for (int c = 0; c < 6; c++) wr_tbl(p, c, 0);
    wr_tbl(0, 0, 1); wr_tbl(1, 2, 1); wr_tbl(2, 2, 1);
    wr_tbl(1, 5, 1); wr_tbl(3, 5, 1); wr_tbl(5, 1, 1);

    // R13: load countdown without an instruction
    @(negedge clk); irq_load = 1'b1; irq_load_val = 32'd1000;
    @(negedge clk); irq_load = 1'b0; m_cd = 1000;
    chk("R13", "irq_countdown load", irq_countdown, 1000);
    chk("R11", "irq_expired positive", irq_expired, 0);

    do_instr("R1",  14, 0, 0, 1);   // first after reset cannot pair: 16
    do_instr("R3",  14, 1, 0, 1);   // table (0,1)=0: 16
    do_instr("R4",  14, 2, 0, 1);   // pair: 12
    do_instr("R4",  14, 2, 0, 1);   // pair again: 12
    do_instr("R3",  14, 1, 0, 1);   // table (2,1)=0: 16
    do_instr("R5",  24, 5, 4, 1);   // pair through penalty: 24
    do_instr("R2",  20, 3, 2, 1);   // prev mod 0: round 22 -> 24
    do_instr("R6",  14, 5, 0, 1);   // prev mod from raw+penalty=22: pair 12
    do_instr("R9",  13, 3, 4, 0);   // plain: 16, history kept
    do_instr("R9",  14, 1, 0, 1);   // (5,1) pairs only if history kept: 12
    m_shift = 1;
    do_instr("R7",  30, 1, 0, 1);   // round 32 >> 1 = 16
    m_shift = 0;

    // R12: table write holds off a valid beat
    @(negedge clk);
    tbl_we = 1'b1; tbl_prev = 6'd1; tbl_cur = 6'd1; tbl_bit = 1'b1;
    in_valid = 1'b1; in_cycles = 8'd200; in_family = 6'd1;
    in_penalty = '0; in_mode_pair = 1'b1;
    #1 chk("R12", "in_ready during write", in_ready, 0);
    @(negedge clk);
    tbl_we = 1'b0; in_valid = 1'b0;
    ref_tbl[1*64 + 1] = 1;
    chk("R12", "main_count stalled", main_count, m_main);
    do_instr("R12", 14, 1, 0, 1);   // new entry (1,1) pairs: 12

    do_instr("R13", 8, 4, 0, 1, 1, 50);   // load wins over subtraction
    do_instr("R11", 60, 4, 0, 1);         // countdown goes to -10

    // random phase
    @(negedge clk); irq_load = 1'b1; irq_load_val = 32'd2000000;
    @(negedge clk); irq_load = 1'b0; m_cd = 2000000;
    for (int k = 0; k < 40; k++)
      wr_tbl($urandom_range(5, 0), $urandom_range(5, 0), 1'($urandom_range(1, 0)));
    for (int k = 0; k < 400; k++) begin
      int pen;
      pen = 2 * $urandom_range(2, 0);
      if ($urandom_range(15, 0) == 0) m_shift = $urandom_range(3, 0);
      do_instr("R3", $urandom_range(255, 0), $urandom_range(5, 0), pen,
               $urandom_range(4, 0) != 0);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule